// File: doc/BRIEF.md
# Masked-Write Synchronizer Mode Register

This block holds the operating mode of a multi-channel camera synchronization unit. Software changes the mode with a single 32-bit register write. Every field in the write word has its own set-enable qualifier. A field changes only when its qualifier is asserted, so one write can update any subset of the settings and leave the others as they are. There is no need to read the register back first.

The outputs are:
- the unit enable;
- the enable for sending a timestamp with each sync pulse;
- a select that chooses between the received timestamp and the local one;
- a select between free-running and triggered (global reset) sensor operation;
- a 2-bit master channel, which is the synchronization source and whose delay also sets flash timing in internal triggered mode;
- a 4-bit channel enable mask.

While the unit enable is clear, a hold output keeps the downstream synchronization logic in reset.

Top module: `sync_mode_reg`

## Requirements
- R1: After reset every field is 0: unit disabled, local timestamp, free-running mode, master channel 0, mask 0. The hold output is 1.
- R2: Each single-bit setting is a 2-bit code: the value in the lower bit and its set-enable in the upper bit. The bit positions are unit enable [1:0], timestamp send [3:2], received-timestamp select [5:4] and triggered mode [7:6]. Code 2'b10 clears the setting and code 2'b11 sets it. The new value is visible one clock after the write edge.
- R3: A single-bit setting whose code is 2'b00 or 2'b01 keeps its current value.
- R4: The master channel takes data bits [9:8] only when bit 10 is 1. Otherwise it is kept.
- R5: The channel mask takes data bits [14:11] only when all four qualifier bits [18:15] are 1. Any other qualifier value keeps the mask.
- R6: A single write updates only the fields it selects. All other fields keep their values.
- R7: A write has no effect when the write strobe is low or the address differs from the mode address (default 8'h04).
- R8: The hold output is 1 whenever the unit enable is 0 and 0 whenever it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 8 | Write address |
| wrData | input | 32 | Write data |
| modEnable | output | 1 | Unit enable |
| tsSendEn | output | 1 | Send timestamp with sync pulse |
| extTsSel | output | 1 | Use the received timestamp |
| trigMode | output | 1 | Triggered (global reset) sensor mode |
| masterChn | output | 2 | Master channel |
| chnMask | output | 4 | Channel enable mask |
| syncHold | output | 1 | Holds the synchronization logic in reset |

## Verification
Each register field updates on the clock edge that captures the write. Its new value is therefore due one cycle after the stimulus, and the hold output follows the unit enable in that same cycle.

The bench drives each write at a falling edge and removes the strobe at the next falling edge. It compares all outputs at that point, which lies after the capturing rising edge and away from it.

Writes that must be ignored are followed by a comparison of every field against the value the bench's own model keeps from earlier writes.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int CHN_NUM   = 4;
  localparam int MASTER_W  = $clog2(CHN_NUM);
  localparam int DATA_W    = 32;

  // flag index: each flag occupies bits [2*i+1:2*i] of the write word
  localparam int FLAG_ENABLE = 0;
  localparam int FLAG_SEND   = 1;
  localparam int FLAG_EXTTS  = 2;
  localparam int FLAG_TRIG   = 3;

  localparam int MASTER_LSB = 2 * NUM_FLAGS;
  localparam int MASTER_SET = MASTER_LSB + MASTER_W;
  localparam int MASK_LSB   = MASTER_SET + 1;
  localparam int QUAL_LSB   = MASK_LSB + CHN_NUM;
  localparam int USED_BITS  = QUAL_LSB + CHN_NUM;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] flagSet;
    logic [NUM_FLAGS-1:0] flagVal;
    logic                 masterSet;
    logic [MASTER_W-1:0]  masterVal;
    logic                 maskSet;
    logic [CHN_NUM-1:0]   maskVal;
  } modeStrobes_t;
endpackage

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import sync_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output modeStrobes_t      strobes
);
  logic hit;
  assign hit = wrEn && (wrAddr == MODE_ADDR);

  always_comb begin
    strobes = '0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      strobes.flagSet[i] = hit && wrData[2*i+1];
      strobes.flagVal[i] = wrData[2*i];
    end
    strobes.masterSet = hit && wrData[MASTER_SET];
    strobes.masterVal = wrData[MASTER_LSB +: MASTER_W];
    strobes.maskSet   = hit && (&wrData[QUAL_LSB +: CHN_NUM]);
    strobes.maskVal   = wrData[MASK_LSB +: CHN_NUM];
  end

  // R7
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || wrAddr != MODE_ADDR) |->
      (strobes.flagSet == '0 && !strobes.masterSet && !strobes.maskSet));

  // R5
  mask_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskSet |-> (wrData[QUAL_LSB +: CHN_NUM] == {CHN_NUM{1'b1}}));
endmodule

// File: rtl/sync_mode_regs.sv
module sync_mode_regs
  import sync_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  modeStrobes_t         strobes,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [MASTER_W-1:0]  master,
  output logic [CHN_NUM-1:0]   mask
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN)                  flags[g] <= 1'b0;
      else if (strobes.flagSet[g]) flags[g] <= strobes.flagVal[g];
    end

    // R3
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.flagSet[g] |=> $stable(flags[g]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      master <= '0;
      mask   <= '0;
    end else begin
      if (strobes.masterSet) master <= strobes.masterVal;
      if (strobes.maskSet)   mask   <= strobes.maskVal;
    end
  end

  // R4
  master_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.masterSet |=> $stable(master));

  // R5
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.maskSet |=> $stable(mask));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |=> (flags == '0 && master == '0 && mask == '0));
endmodule

// File: rtl/sync_mode_reg.sv
module sync_mode_reg
  import sync_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output logic              modEnable,
  output logic              tsSendEn,
  output logic              extTsSel,
  output logic              trigMode,
  output logic [1:0]        masterChn,
  output logic [3:0]        chnMask,
  output logic              syncHold
);
  modeStrobes_t         strobes;
  logic [NUM_FLAGS-1:0] flags;

  sync_mode_ctrl #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strobes(strobes)
  );

  sync_mode_regs regs_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .flags(flags), .master(masterChn), .mask(chnMask)
  );

  assign modEnable = flags[FLAG_ENABLE];
  assign tsSendEn  = flags[FLAG_SEND];
  assign extTsSel  = flags[FLAG_EXTTS];
  assign trigMode  = flags[FLAG_TRIG];
  assign syncHold  = !flags[FLAG_ENABLE];
endmodule

// File: tb/sync_mode_reg_tb.sv
module sync_mode_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = 8'h00;
  logic [31:0] wrData = 32'h0;
  logic        modEnable, tsSendEn, extTsSel, trigMode, syncHold;
  logic [1:0]  masterChn;
  logic [3:0]  chnMask;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [3:0] mFlags = 4'h0;
  logic [1:0] mMaster = 2'h0;
  logic [3:0] mMask = 4'h0;

  always #2 clk = ~clk;

  sync_mode_reg dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .modEnable(modEnable), .tsSendEn(tsSendEn), .extTsSel(extTsSel),
    .trigMode(trigMode), .masterChn(masterChn), .chnMask(chnMask),
    .syncHold(syncHold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, {28'h0, trigMode, extTsSel, tsSendEn, modEnable}, {28'h0, mFlags});
    check(req, {30'h0, masterChn}, {30'h0, mMaster});
    check(req, {28'h0, chnMask}, {28'h0, mMask});
    check(req, {31'h0, syncHold}, {31'h0, ~mFlags[0]});
  endtask

  // Drive one write at a falling edge; sample at the following falling edge.
  task automatic doWrite(input logic [7:0] addr, input logic [31:0] data, input logic en);
    @(negedge clk);
    wrEn = en; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = 32'h0;
  endtask

  function automatic logic [31:0] flagCode(input int idx, input logic [1:0] code);
    return {30'h0, code} << (2 * idx);
  endfunction

  task automatic testReset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mFlags = 0; mMaster = 0; mMask = 0;
    checkAll("R1");
  endtask

  task automatic testFlags;
    for (int i = 0; i < 4; i++) begin
      doWrite(8'h04, flagCode(i, 2'b11), 1'b1);
      mFlags[i] = 1'b1;
      checkAll("R2 set");
    end
    for (int i = 0; i < 4; i++) begin
      doWrite(8'h04, flagCode(i, 2'b10), 1'b1);
      mFlags[i] = 1'b0;
      checkAll("R2 clear");
    end
  endtask

  task automatic testKeep;
    doWrite(8'h04, 32'h000000FF, 1'b1);  // all four flags set
    mFlags = 4'hF;
    checkAll("R2 all");
    doWrite(8'h04, 32'h00000000, 1'b1);  // codes 00
    checkAll("R3 code00");
    doWrite(8'h04, 32'h00000055, 1'b1);  // codes 01
    checkAll("R3 code01");
    doWrite(8'h04, 32'h000000AA, 1'b1);  // clear all
    mFlags = 4'h0;
    doWrite(8'h04, 32'h00000055, 1'b1);
    checkAll("R3 code01 zero");
  endtask

  task automatic testMaster;
    doWrite(8'h04, (32'h1 << 10) | (32'h3 << 8), 1'b1);
    mMaster = 2'd3;
    checkAll("R4 write3");
    doWrite(8'h04, (32'h1 << 8), 1'b1);  // no enable bit
    checkAll("R4 keep");
    doWrite(8'h04, (32'h1 << 10) | (32'h2 << 8), 1'b1);
    mMaster = 2'd2;
    checkAll("R4 write2");
  endtask

  task automatic testMask;
    doWrite(8'h04, (32'hF << 15) | (32'hA << 11), 1'b1);
    mMask = 4'hA;
    checkAll("R5 write");
    doWrite(8'h04, (32'h7 << 15) | (32'h5 << 11), 1'b1);
    checkAll("R5 partial qual");
    doWrite(8'h04, (32'h8 << 15) | (32'h5 << 11), 1'b1);
    checkAll("R5 one qual bit");
    doWrite(8'h04, (32'hF << 15) | (32'h0 << 11), 1'b1);
    mMask = 4'h0;
    checkAll("R5 clear");
    doWrite(8'h04, (32'hF << 15) | (32'hF << 11), 1'b1);
    mMask = 4'hF;
    checkAll("R5 full");
  endtask

  task automatic testIndependent;
    // set trig flag and mask only; enable/send/ext and master untouched
    doWrite(8'h04, flagCode(3, 2'b11) | (32'hF << 15) | (32'h6 << 11), 1'b1);
    mFlags[3] = 1'b1; mMask = 4'h6;
    checkAll("R6 trig+mask");
    doWrite(8'h04, flagCode(0, 2'b11) | (32'h1 << 10) | (32'h1 << 8), 1'b1);
    mFlags[0] = 1'b1; mMaster = 2'd1;
    checkAll("R6 enable+master");
  endtask

  task automatic testIgnore;
    doWrite(8'h05, 32'hFFFFFFFF, 1'b1);
    checkAll("R7 wrong addr");
    doWrite(8'h04, 32'h0007FFAA, 1'b0);
    checkAll("R7 no strobe");
    doWrite(8'h84, 32'h0007FFAA, 1'b1);
    checkAll("R7 high addr bit");
  endtask

  task automatic testHold;
    doWrite(8'h04, flagCode(0, 2'b10), 1'b1);
    mFlags[0] = 1'b0;
    check("R8 hold on", {31'h0, syncHold}, 32'h1);
    doWrite(8'h04, flagCode(0, 2'b11), 1'b1);
    mFlags[0] = 1'b1;
    check("R8 hold off", {31'h0, syncHold}, 32'h0);
    checkAll("R8");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testFlags();
    testKeep();
    testMaster();
    testMask();
    testIndependent();
    testIgnore();
    testHold();
    testReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule